// File: doc/BRIEF.md
# Configuration Item DMA Engine

This block is a memory-mapped configuration-data device. Firmware chooses a data item through a selector register. It then either pulls the item one byte at a time through a data register, or hands the block a pointer to a 16-byte descriptor in system memory. The block fetches that descriptor, copies the requested bytes of the current item into memory, and writes the updated descriptor back so that firmware can see the progress and the outcome.

The descriptor is stored big-endian and holds three fields: a 64-bit target address, a 32-bit byte count and a 32-bit control word. A target address of zero turns the copy into a skip, which moves the item offset forward without touching memory. The memory side is a byte-wide request/valid master. The item contents come from a small computed store inside the block.

Top module: `cfg_dma_dev`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o` and `reg_rdata_o` are 0, the selected item is 0 and its offset is 0.
- R2: A write to word 2 (`reg_word_i`=2) selects item `reg_wdata_i[15:0]` and clears the offset. Item k has length 4+3k for k<4, and length 0 for any other selector value. Byte j of item k is {k[3:0], j[3:0]} XOR 0xA5.
- R3: A read of word 0 or word 1 returns the byte at the current offset in `reg_rdata_o[7:0]` one cycle later, and then advances the offset. At or past the end of the item, the read returns 0 and the offset is unchanged.
- R4: A write to word 3 stores the upper 32 bits of the pointer and does nothing else. A write to word 4 supplies the lower 32 bits and starts a transfer at the combined pointer.
- R5: The block reads the descriptor as 16 bytes starting at the pointer. Bytes 0–7 hold the target address, bytes 8–11 the length and bytes 12–15 the control word, each most significant byte first.
- R6: With control 2 and a nonzero target, the block writes item bytes to ascending target addresses. It then writes the descriptor back with address = target+length, length 0 and control 0.
- R7: With control 2 and target 0, the block writes nothing to memory and the offset advances by the length. The write-back holds address 0, length 0 and control 0.
- R8: Any control value other than 2 copies nothing and leaves the offset unchanged. The write-back keeps address and length and sets control to 1 (bit 0 is the error flag).
- R9: If the item ends before the length is used up, the copy stops there. The write-back holds address = target + bytes copied, length = bytes remaining, and control 1.
- R10: Data-register reads and DMA copies advance the same offset counter.
- R11: `busy_o` stays high from the trigger until the last write-back byte is accepted. While it is high, pointer writes and selector writes are ignored and data reads return 0 without advancing the offset.
- R12: Once raised, `mem_req_o` holds, with stable address, direction and write data, until a cycle in which `mem_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_word_i | input | 3 | 32-bit word index in the 0x14-byte window |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the strobe |
| busy_o | output | 1 | Transfer in progress |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr_o | output | 64 | Byte address of the beat |
| mem_wdata_o | output | 8 | Write byte |
| mem_valid_i | input | 1 | Beat accepted; read data valid |
| mem_rdata_i | input | 8 | Read byte |

## Verification
The bench uses the default parameters: four items of lengths 4, 7, 10 and 13. These are short enough that a single descriptor can copy an entire item, and long enough that one can also run past its end, so both the clean-finish path and the overrun path are reachable. The mix of data-register reads, skips and copies on the same item exercises the shared offset. Issuing a selector write and a second trigger in the middle of a transfer shows that both are ignored while the block is busy.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_COPY, S_WB} eng_state_e;

  localparam int unsigned DESC_BYTES = 16;
  localparam logic [31:0] CTRL_READ  = 32'd2;
  localparam logic [31:0] CTRL_OK    = 32'd0;
  localparam logic [31:0] CTRL_ERR   = 32'd1;

  function automatic logic [7:0] item_byte(input logic [15:0] sel, input logic [31:0] off);
    return {sel[3:0], off[3:0]} ^ 8'hA5;
  endfunction
endpackage

// File: rtl/cfg_item_rom.sv
module cfg_item_rom #(
  parameter int unsigned NUM_ITEMS = 4,
  parameter int unsigned BASE_LEN  = 4,
  parameter int unsigned STEP_LEN  = 3
) (
  input  logic [15:0] sel_i,
  input  logic [31:0] off_i,
  output logic [7:0]  byte_o,
  output logic [31:0] len_o
);
  logic [31:0] len_tab [NUM_ITEMS];

  for (genvar k = 0; k < NUM_ITEMS; k++) begin : g_len
    assign len_tab[k] = 32'(BASE_LEN + STEP_LEN * k);
  end

  always_comb begin
    len_o = '0;
    for (int k = 0; k < NUM_ITEMS; k++)
      if (sel_i == 16'(k)) len_o = len_tab[k];
  end

  assign byte_o = cfg_dma_pkg::item_byte(sel_i, off_i);
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [31:0]       off_i,
  input  logic [31:0]       item_len_i,
  input  logic [7:0]        item_byte_i,
  output logic              off_inc_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_rdata_i
);
  localparam int unsigned DESC_W = DESC_BYTES * 8;
  localparam int unsigned CNT_W  = $clog2(DESC_BYTES);

  eng_state_e         state_q;
  logic [ADDR_W-1:0]  ptr_q, tgt_q;
  logic [31:0]        len_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DESC_W-1:0]  shift_q;
  logic               skip_q;
  logic               at_end;

  assign at_end = off_i >= item_len_i;
  assign busy_o = state_q != S_IDLE;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_q + ADDR_W'(cnt_q);
    mem_wdata_o = shift_q[DESC_W-1 -: 8];
    off_inc_o   = 1'b0;
    unique case (state_q)
      S_FETCH: mem_req_o = 1'b1;
      S_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      S_COPY: if (len_q != 0 && !at_end) begin
        if (skip_q) off_inc_o = 1'b1;
        else begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = tgt_q;
          mem_wdata_o = item_byte_i;
          off_inc_o   = mem_valid_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      tgt_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      shift_q <= '0;
      skip_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          ptr_q   <= ptr_i;
          cnt_q   <= '0;
          state_q <= S_FETCH;
        end
        S_FETCH: if (mem_valid_i) begin
          shift_q <= {shift_q[DESC_W-9:0], mem_rdata_i};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DESC_BYTES - 1)) state_q <= S_CHECK;
        end
        S_CHECK: begin
          tgt_q  <= shift_q[DESC_W-1 -: ADDR_W];
          len_q  <= shift_q[63:32];
          skip_q <= shift_q[DESC_W-1 -: ADDR_W] == '0;
          if (shift_q[31:0] != CTRL_READ) begin
            shift_q[31:0] <= CTRL_ERR;
            state_q       <= S_WB;
          end else begin
            state_q <= S_COPY;
          end
        end
        S_COPY: begin
          if (len_q == 0) begin
            shift_q <= {tgt_q, len_q, CTRL_OK};
            state_q <= S_WB;
          end else if (at_end) begin
            shift_q <= {tgt_q, len_q, CTRL_ERR};
            state_q <= S_WB;
          end else if (skip_q) begin
            len_q <= len_q - 1'b1;
          end else if (mem_valid_i) begin
            tgt_q <= tgt_q + 1'b1;
            len_q <= len_q - 1'b1;
          end
        end
        S_WB: if (mem_valid_i) begin
          shift_q <= {shift_q[DESC_W-9:0], 8'h00};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DESC_BYTES - 1)) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                     && $stable(mem_wdata_o))); // R12
  AST_SKIP_NO_ZERO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_COPY && mem_req_o && mem_we_o) |-> mem_addr_o != '0); // R7
  AST_BUSY_ENDS_IN_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(state_q == S_WB && mem_valid_i)); // R11
endmodule

// File: rtl/cfg_dma_dev.sv
module cfg_dma_dev
  import cfg_dma_pkg::*;
#(
  parameter int unsigned NUM_ITEMS = 4,
  parameter int unsigned BASE_LEN  = 4,
  parameter int unsigned STEP_LEN  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [2:0]  reg_word_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        busy_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [63:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic        mem_valid_i,
  input  logic [7:0]  mem_rdata_i
);
  localparam logic [2:0] W_SEL = 3'd2, W_PHI = 3'd3, W_PLO = 3'd4;

  logic [15:0] sel_q;
  logic [31:0] off_q, ptr_hi_q, item_len;
  logic [7:0]  item_b;
  logic        data_hit, sel_wr, start, eng_inc;

  assign data_hit = reg_word_i[2:1] == 2'b00;
  assign sel_wr   = reg_we_i && reg_word_i == W_SEL && !busy_o;
  assign start    = reg_we_i && reg_word_i == W_PLO && !busy_o;

  cfg_item_rom #(.NUM_ITEMS(NUM_ITEMS), .BASE_LEN(BASE_LEN), .STEP_LEN(STEP_LEN)) u_rom (
    .sel_i (sel_q), .off_i (off_q), .byte_o(item_b), .len_o(item_len)
  );

  cfg_dma_engine #(.ADDR_W(64)) u_eng (
    .clk_i, .rst_ni,
    .start_i    (start),
    .ptr_i      ({ptr_hi_q, reg_wdata_i}),
    .off_i      (off_q),
    .item_len_i (item_len),
    .item_byte_i(item_b),
    .off_inc_o  (eng_inc),
    .busy_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_valid_i, .mem_rdata_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= '0;
      off_q       <= '0;
      ptr_hi_q    <= '0;
      reg_rdata_o <= '0;
    end else begin
      if (reg_we_i && reg_word_i == W_PHI && !busy_o) ptr_hi_q <= reg_wdata_i;
      if (sel_wr) begin
        sel_q <= reg_wdata_i[15:0];
        off_q <= '0;
      end else if (eng_inc) begin
        off_q <= off_q + 1'b1;
      end
      if (reg_re_i) begin
        reg_rdata_o <= '0;
        if (reg_word_i == W_SEL) reg_rdata_o <= {16'h0, sel_q};
        else if (data_hit && !busy_o && off_q < item_len) begin
          reg_rdata_o <= {24'h0, item_b};
          if (!sel_wr) off_q <= off_q + 1'b1;
        end
      end
    end
  end

  AST_OFF_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q <= item_len); // R9
  AST_SEL_CLEARS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> off_q == 0); // R2
endmodule

// File: tb/cfg_dma_dev_test.sv
module cfg_dma_dev_test;
  logic        clk = 0, rst_n = 0;
  logic        we = 0, re = 0;
  logic [2:0]  word = 0;
  logic [31:0] wdata = 0, rdata;
  logic        busy, req, mwe, mvalid;
  logic [63:0] maddr;
  logic [7:0]  mwdata, mrdata;
  logic [7:0]  mem [0:1023];
  logic [63:0] exp_a [$];
  logic [7:0]  exp_d [$];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cfg_dma_dev uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_word_i(word),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_o(busy), .mem_req_o(req),
    .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_valid_i(mvalid), .mem_rdata_i(mrdata)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // memory model and write-beat monitor (R6, R7, R9, R12)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mvalid <= 0; mrdata <= 0;
    end else if (req && !mvalid) begin
      mvalid <= 1;
      if (mwe) begin
        mem[maddr[9:0]] <= mwdata;
        checks++;
        if (exp_a.size() == 0) begin
          errors++;
          $display("FAIL R6 unexpected write actual=%0h:%0h expected=none", maddr, mwdata);
        end else begin
          logic [63:0] ea; logic [7:0] ed;
          ea = exp_a.pop_front(); ed = exp_d.pop_front();
          if (ea !== maddr || ed !== mwdata) begin
            errors++;
            $display("FAIL R6 write actual=%0h:%0h expected=%0h:%0h", maddr, mwdata, ea, ed);
          end
        end
      end else mrdata <= mem[maddr[9:0]];
    end else mvalid <= 0;
  end

  function automatic logic [7:0] ib(input int k, input int j);
    return {4'(k), 4'(j)} ^ 8'hA5;
  endfunction

  task automatic reg_wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk); we = 1; word = w; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk); re = 1; word = w;
    @(negedge clk); re = 0; d = rdata;
  endtask

  task automatic put_desc(input logic [63:0] t, input logic [31:0] l, input logic [31:0] c);
    logic [127:0] v = {t, l, c};
    for (int i = 0; i < 16; i++) mem[10'h100 + i] = v[127 - 8*i -: 8];
  endtask

  task automatic push_wb(input logic [63:0] t, input logic [31:0] l, input logic [31:0] c);
    logic [127:0] v = {t, l, c};
    for (int i = 0; i < 16; i++) begin
      exp_a.push_back(64'h100 + 64'(i)); exp_d.push_back(v[127 - 8*i -: 8]);
    end
  endtask

  task automatic push_copy(input logic [63:0] t, input int k, input int j0, input int n);
    for (int i = 0; i < n; i++) begin
      exp_a.push_back(t + 64'(i)); exp_d.push_back(ib(k, j0 + i));
    end
  endtask

  task automatic wait_idle(input string r);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    chk(r, {63'd0, busy}, 0);
    repeat (3) @(negedge clk);
    chk(r, exp_a.size(), 0);
  endtask

  task automatic fire;
    reg_wr(3'd3, 32'h0);
    reg_wr(3'd4, 32'h100);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1", {rdata, 29'd0, busy, req, mwe}, 0);
    rst_n = 1;
    reg_rd(3'd2, d); chk("R1 sel", d, 0);
    reg_rd(3'd0, d); chk("R1 off", d, ib(0, 0));

    // R2 R3: select item 1, read three bytes
    reg_wr(3'd2, 32'd1);
    reg_rd(3'd0, d); chk("R2", d, ib(1, 0));
    reg_rd(3'd1, d); chk("R3", d, ib(1, 1));
    reg_rd(3'd0, d); chk("R3", d, ib(1, 2));

    // R5 R6 R10: copy remaining 4 bytes of item 1 to 0x200
    put_desc(64'h200, 32'd4, 32'd2);
    push_copy(64'h200, 1, 3, 4);
    push_wb(64'h204, 32'd0, 32'd0);
    fire(); chk("R11 busy", {63'd0, busy}, 1);
    wait_idle("R6");
    reg_rd(3'd0, d); chk("R10 R3 end", d, 0);
    reg_rd(3'd0, d); chk("R3 end hold", d, 0);

    // R7: skip 3 bytes of item 2
    reg_wr(3'd2, 32'd2);
    put_desc(64'h0, 32'd3, 32'd2);
    push_wb(64'h0, 32'd0, 32'd0);
    fire(); wait_idle("R7");
    reg_rd(3'd0, d); chk("R7 offset", d, ib(2, 3));

    // R8: bad control
    put_desc(64'h240, 32'd5, 32'd5);
    push_wb(64'h240, 32'd5, 32'd1);
    fire(); wait_idle("R8");
    reg_rd(3'd0, d); chk("R8 offset", d, ib(2, 4));

    // R4: upper half alone does not start
    reg_wr(3'd3, 32'h0);
    repeat (4) @(negedge clk);
    chk("R4", {63'd0, busy}, 0);

    // R9: overrun on item 0 (len 4), request 6
    reg_wr(3'd2, 32'd0);
    put_desc(64'h300, 32'd6, 32'd2);
    push_copy(64'h300, 0, 0, 4);
    push_wb(64'h304, 32'd2, 32'd1);
    fire(); wait_idle("R9");

    // R11: selector write and retrigger ignored while busy
    reg_wr(3'd2, 32'd2);
    put_desc(64'h280, 32'd2, 32'd2);
    push_copy(64'h280, 2, 0, 2);
    push_wb(64'h282, 32'd0, 32'd0);
    fire();
    reg_wr(3'd2, 32'd3);
    reg_rd(3'd0, d); chk("R11 read while busy", d, 0);
    reg_wr(3'd4, 32'h100);
    wait_idle("R11");
    reg_rd(3'd2, d); chk("R11 sel kept", d, 2);
    reg_rd(3'd0, d); chk("R11 offset", d, ib(2, 2));

    // R2: out-of-range selector has length 0
    reg_wr(3'd2, 32'd9);
    reg_rd(3'd0, d); chk("R2 empty item", d, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule